// File: doc/BRIEF.md
# I/O Address Translation Table Walker

This block turns a 32-bit device-side virtual address into a physical frame number by walking a two-level table held in memory. Every address space has an identifier (ASID) and a root entry that points at its directory table. Software programs a root entry in two steps. It first writes the ASID into a selector register. It then writes a word into the data register, and that word becomes the root entry of the selected space. The root entry carries the directory frame number in its low 20 bits and the read, write and non-secure permissions in its top three bits.

A request names an ASID, an address and an access type (read or write). The walker checks the root entry's permission for that access. It then fetches the directory entry, which is indexed by address bits [31:22], and checks it. Next it fetches the leaf entry, which is indexed by address bits [21:12] inside the table the directory points to. Finally it returns the leaf's frame number and permissions, or a fault code. It has one narrow read port to memory, uses a valid/ready request handshake and keeps at most one read outstanding. It handles one translation at a time, and it shows it is occupied on `busy`.

Top module: `iopt_walker`

## Requirements
- R1: A pulse on `cfg_idx_we` loads `cfg_wdata[6:0]` into the ASID selector, and the upper bits are ignored. A pulse on `cfg_data_we` stores the whole of `cfg_wdata` as the root entry of the selected ASID. Root entry bits: [19:0] directory frame, 31 readable, 30 writable, 29 non-secure.
- R2: After reset, `busy`, `rsp_valid` and `mem_req_valid` are 0 and `req_ready` is 1. Every ASID counts as unprogrammed, which means its root entry reads as zero.
- R3: The directory read address is {root[19:0], va[31:22], 2'b00}. The leaf read address is {dir[19:0], va[21:12], 2'b00}. No other reads are issued.
- R4: If the directory entry is zero, or its bit 28 (next-level flag) is clear, the walker responds with fault kind 2 and issues no leaf read.
- R5: A read access needs bit 31 and a write access needs bit 30. If the root entry lacks the needed bit, the walker responds with fault kind 1 and issues no memory read.
- R6: If the directory entry (after the R4 check) or the leaf entry lacks the needed bit, the walker responds with fault kind 3. A leaf entry of zero therefore gives kind 3.
- R7: On success, `rsp_fault`=0, `rsp_kind`=0, `rsp_pfn`=leaf[19:0] and `rsp_perm`=leaf[31:29] (bit 2 readable, bit 1 writable, bit 0 non-secure).
- R8: `mem_req_valid` stays high with a stable `mem_addr` until `mem_req_ready` is seen. The next read is issued only after `mem_rsp_valid` for the previous one.
- R9: `busy` rises in the cycle after a request is accepted (`req_valid` while `req_ready`, with `req_ready` equal to the inverse of `busy`). `rsp_valid` is a one-cycle pulse, and the walker is idle in the cycle after it.
- R10: On a fault, `rsp_fault`=1, and `rsp_pfn` and `rsp_perm` are zero. Faults are checked in this order: root permission, missing table, directory permission, leaf permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx_we | input | 1 | Load the ASID selector from `cfg_wdata` |
| cfg_data_we | input | 1 | Store `cfg_wdata` as root entry of the selected ASID |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_asid | input | 7 | Address space of the request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_kind | output | 2 | 0 ok, 1 root permission, 2 no table, 3 entry permission |
| rsp_pfn | output | 20 | Physical frame number |
| rsp_perm | output | 3 | Leaf {readable, writable, non-secure} |
| busy | output | 1 | A translation is in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
A corrupted walk state shows up at the memory port within one read. Typical symptoms are an address built from the wrong frame or index, a leaf read after a failed directory check, or a second read before the first returns. The bench records every accepted read address and compares the list to the expected walk after each response. A wrong fault priority or frame latch shows in the fields of the very next `rsp_valid` pulse. A stuck state machine shows as `busy` still high in the cycle after the pulse.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int unsigned ENT_W  = 32;
  localparam int unsigned PFN_W  = 20;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned VA_W   = 2 * IDX_W + OFF_W;
  localparam int unsigned PA_W   = PFN_W + OFF_W;
  localparam int unsigned B_RD   = 31;
  localparam int unsigned B_WR   = 30;
  localparam int unsigned B_NS   = 29;
  localparam int unsigned B_NEXT = 28;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ROOT    = 2'd1,
    FLT_NOTABLE = 2'd2,
    FLT_PERM    = 2'd3
  } flt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROOT,
    ST_DIR,
    ST_LEAF,
    ST_RESP
  } wst_e;
endpackage

// File: rtl/iopt_root_regs.sv
module iopt_root_regs
  import iopt_pkg::*;
#(
  parameter int unsigned ASID_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_we,
  input  logic              data_we,
  input  logic [ENT_W-1:0]  wdata,
  input  logic [ASID_W-1:0] rd_asid,
  output logic [ENT_W-1:0]  rd_entry
);
  localparam int unsigned NSP = 1 << ASID_W;

  logic [ASID_W-1:0] sel_q;
  logic [ENT_W-1:0]  ram [NSP];
  logic [ENT_W-1:0]  ram_q;
  logic [NSP-1:0]    set_q;
  logic              set_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      set_q    <= '0;
      set_rd_q <= 1'b0;
    end else begin
      if (idx_we) sel_q <= wdata[ASID_W-1:0];
      if (data_we) set_q[sel_q] <= 1'b1;
      set_rd_q <= set_q[rd_asid];
    end
  end

  // Simple dual-port storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (data_we) ram[sel_q] <= wdata;
    ram_q <= ram[rd_asid];
  end

  assign rd_entry = set_rd_q ? ram_q : '0;
endmodule

// File: rtl/iopt_entry_check.sv
module iopt_entry_check
  import iopt_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic             is_dir,
  input  logic             wr,
  output logic             no_table,
  output logic             perm_ok
);
  always_comb begin
    no_table = is_dir && ((entry == '0) || !entry[B_NEXT]);
    perm_ok  = wr ? entry[B_WR] : entry[B_RD];
  end
endmodule

// File: rtl/iopt_walk_fsm.sv
module iopt_walk_fsm
  import iopt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [VA_W-1:OFF_W]   req_vpn,
  input  logic                  req_write,
  input  logic [PFN_W-1:0]      root_pfn,
  input  logic                  root_ok,
  input  logic                  ent_no_table,
  input  logic                  ent_ok,
  input  logic [PFN_W-1:0]      ent_pfn,
  input  logic [2:0]            ent_perm,
  input  logic                  mem_req_ready,
  input  logic                  mem_rsp_valid,
  output logic                  busy,
  output logic                  walk_wr,
  output logic                  walk_in_dir,
  output logic                  mem_req_valid,
  output logic [PA_W-1:0]       mem_addr,
  output logic                  rsp_valid,
  output logic                  rsp_fault,
  output logic [1:0]            rsp_kind,
  output logic [PFN_W-1:0]      rsp_pfn,
  output logic [2:0]            rsp_perm
);
  wst_e                 st_q;
  logic [VA_W-1:OFF_W]  vpn_q;
  logic                 wr_q;
  logic                 mv_q;
  logic [PA_W-1:0]      ma_q;
  logic                 rv_q;
  logic                 rf_q;
  logic [1:0]           rk_q;
  logic [PFN_W-1:0]     rp_q;
  logic [2:0]           rperm_q;
  logic                 rsp_seen;

  // read data is only consumed once the request phase is over
  assign rsp_seen = !mv_q && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      vpn_q   <= '0;
      wr_q    <= 1'b0;
      mv_q    <= 1'b0;
      ma_q    <= '0;
      rv_q    <= 1'b0;
      rf_q    <= 1'b0;
      rk_q    <= FLT_NONE;
      rp_q    <= '0;
      rperm_q <= '0;
    end else begin
      rv_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q <= req_vpn;
            wr_q  <= req_write;
            st_q  <= ST_ROOT;
          end
        end
        ST_ROOT: begin
          if (!root_ok) begin
            rv_q <= 1'b1; rf_q <= 1'b1; rk_q <= FLT_ROOT;
            rp_q <= '0;   rperm_q <= '0; st_q <= ST_RESP;
          end else begin
            mv_q <= 1'b1;
            ma_q <= {root_pfn, vpn_q[VA_W-1 -: IDX_W], 2'b00};
            st_q <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (mv_q) begin
            if (mem_req_ready) mv_q <= 1'b0;
          end else if (rsp_seen) begin
            if (ent_no_table) begin
              rv_q <= 1'b1; rf_q <= 1'b1; rk_q <= FLT_NOTABLE;
              rp_q <= '0;   rperm_q <= '0; st_q <= ST_RESP;
            end else if (!ent_ok) begin
              rv_q <= 1'b1; rf_q <= 1'b1; rk_q <= FLT_PERM;
              rp_q <= '0;   rperm_q <= '0; st_q <= ST_RESP;
            end else begin
              mv_q <= 1'b1;
              ma_q <= {ent_pfn, vpn_q[OFF_W +: IDX_W], 2'b00};
              st_q <= ST_LEAF;
            end
          end
        end
        ST_LEAF: begin
          if (mv_q) begin
            if (mem_req_ready) mv_q <= 1'b0;
          end else if (rsp_seen) begin
            rv_q <= 1'b1;
            st_q <= ST_RESP;
            if (!ent_ok) begin
              rf_q <= 1'b1; rk_q <= FLT_PERM; rp_q <= '0; rperm_q <= '0;
            end else begin
              rf_q <= 1'b0; rk_q <= FLT_NONE; rp_q <= ent_pfn; rperm_q <= ent_perm;
            end
          end
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign walk_wr       = wr_q;
  assign walk_in_dir   = (st_q == ST_DIR);
  assign mem_req_valid = mv_q;
  assign mem_addr      = ma_q;
  assign rsp_valid     = rv_q;
  assign rsp_fault     = rf_q;
  assign rsp_kind      = rk_q;
  assign rsp_pfn       = rp_q;
  assign rsp_perm      = rperm_q;
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
  import iopt_pkg::*;
#(
  parameter int unsigned ASID_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_idx_we,
  input  logic              cfg_data_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [31:0]       req_va,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [1:0]        rsp_kind,
  output logic [19:0]       rsp_pfn,
  output logic [2:0]        rsp_perm,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  logic [ENT_W-1:0] root_entry;
  logic             root_ok;
  logic             root_nt_unused;
  logic             ent_no_table;
  logic             ent_ok;
  logic             walk_wr;
  logic             walk_in_dir;
  logic             busy_w;
  logic [OFF_W-1:0] unused_offset;

  assign unused_offset = req_va[OFF_W-1:0];

  iopt_root_regs #(.ASID_W(ASID_W)) u_roots (
    .clk     (clk),
    .rst     (rst),
    .idx_we  (cfg_idx_we),
    .data_we (cfg_data_we),
    .wdata   (cfg_wdata),
    .rd_asid (req_asid),
    .rd_entry(root_entry)
  );

  iopt_entry_check u_root_chk (
    .entry   (root_entry),
    .is_dir  (1'b0),
    .wr      (walk_wr),
    .no_table(root_nt_unused),
    .perm_ok (root_ok)
  );

  iopt_entry_check u_ent_chk (
    .entry   (mem_rsp_data),
    .is_dir  (walk_in_dir),
    .wr      (walk_wr),
    .no_table(ent_no_table),
    .perm_ok (ent_ok)
  );

  iopt_walk_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_vpn      (req_va[VA_W-1:OFF_W]),
    .req_write    (req_write),
    .root_pfn     (root_entry[PFN_W-1:0]),
    .root_ok      (root_ok),
    .ent_no_table (ent_no_table),
    .ent_ok       (ent_ok),
    .ent_pfn      (mem_rsp_data[PFN_W-1:0]),
    .ent_perm     (mem_rsp_data[B_RD:B_NS]),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .busy         (busy_w),
    .walk_wr      (walk_wr),
    .walk_in_dir  (walk_in_dir),
    .mem_req_valid(mem_req_valid),
    .mem_addr     (mem_addr),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_kind     (rsp_kind),
    .rsp_pfn      (rsp_pfn),
    .rsp_perm     (rsp_perm)
  );

  assign busy      = busy_w;
  assign req_ready = !busy_w;
endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk #(
  parameter int unsigned ASID_W = 7
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [1:0]  rsp_kind,
  input logic [19:0] rsp_pfn,
  input logic [2:0]  rsp_perm,
  input logic        busy,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_addr
);
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy); // R9
  AST_RSP_IDLE_AFTER: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !busy); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr))); // R8
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid); // R8
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_addr[1:0] == 2'b00)); // R3
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_pfn == '0 && rsp_perm == '0 && rsp_kind != 2'd0)); // R10
  AST_OK_KIND: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_kind == 2'd0)); // R7
endmodule

bind iopt_walker iopt_walker_chk #(.ASID_W(ASID_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_kind     (rsp_kind),
  .rsp_pfn      (rsp_pfn),
  .rsp_perm     (rsp_perm),
  .busy         (busy),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_addr     (mem_addr)
);

// File: tb/sim_iopt_walker.sv
module sim_iopt_walker;
  localparam int ASID_W = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        cfg_idx_we, cfg_data_we;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_ready, req_write;
  logic [6:0]  req_asid;
  logic [31:0] req_va;
  logic        rsp_valid, rsp_fault, busy;
  logic [1:0]  rsp_kind;
  logic [19:0] rsp_pfn;
  logic [2:0]  rsp_perm;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_addr, mem_rsp_data;

  iopt_walker #(.ASID_W(ASID_W)) u0 (
    .clk(clk), .rst(rst), .cfg_idx_we(cfg_idx_we), .cfg_data_we(cfg_data_we),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_asid(req_asid), .req_va(req_va), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_kind(rsp_kind),
    .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  logic [31:0] memw [logic [31:0]];
  logic [31:0] root_tb [128];
  bit          prog_tb [128];
  logic [31:0] addr_log [$];
  int          total = 0;
  int          bad = 0;
  int          lat = 0;
  logic [31:0] pend_addr;
  logic [1:0]  last_kind;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return memw.exists(a) ? memw[a] : 32'h0;
  endfunction

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, got, exp);
    end
  endtask

  // memory model: random accept stalls, 1..3 cycle read latency
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; pend_addr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (lat > 0) begin
        mem_req_ready = 1'b0;
        lat--;
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rdm(pend_addr);
        end
      end else begin
        mem_req_ready = (($urandom % 4) != 0);
        if (mem_req_valid && mem_req_ready) begin
          pend_addr = mem_addr;
          addr_log.push_back(mem_addr);
          lat = 1 + ($urandom % 3);
        end
      end
    end
  end

  task automatic model(input int asid, input logic [31:0] va, input bit wr,
                       output logic [1:0] kind, output logic [19:0] pfn, output logic [2:0] perm,
                       output int na, output logic [31:0] a0, output logic [31:0] a1);
    logic [31:0] root, pde, pte;
    int need;
    need = wr ? 30 : 31;
    root = prog_tb[asid] ? root_tb[asid] : 32'h0;
    kind = 2'd0; pfn = '0; perm = '0; na = 0; a0 = '0; a1 = '0;
    if (!root[need]) kind = 2'd1;
    else begin
      a0 = {root[19:0], va[31:22], 2'b00}; na = 1; pde = rdm(a0);
      if (pde == 32'h0 || !pde[28]) kind = 2'd2;
      else if (!pde[need]) kind = 2'd3;
      else begin
        a1 = {pde[19:0], va[21:12], 2'b00}; na = 2; pte = rdm(a1);
        if (!pte[need]) kind = 2'd3;
        else begin pfn = pte[19:0]; perm = pte[31:29]; end
      end
    end
  endtask

  task automatic prog(input logic [31:0] idx_word, input logic [31:0] data);
    @(negedge clk); cfg_idx_we = 1'b1; cfg_wdata = idx_word;
    @(negedge clk); cfg_idx_we = 1'b0; cfg_data_we = 1'b1; cfg_wdata = data;
    @(negedge clk); cfg_data_we = 1'b0; cfg_wdata = '0;
    root_tb[idx_word[6:0]] = data;
    prog_tb[idx_word[6:0]] = 1'b1;
  endtask

  task automatic run(input int asid, input logic [31:0] va, input bit wr);
    logic [1:0]  ek; logic [19:0] ep; logic [2:0] eperm;
    int na; logic [31:0] a0, a1;
    string rq;
    int n;
    model(asid, va, wr, ek, ep, eperm, na, a0, a1);
    rq = (ek == 2'd1) ? "R5" : (ek == 2'd2) ? "R4" : (ek == 2'd3) ? "R6" : "R7";
    addr_log.delete();
    @(negedge clk);
    req_valid = 1'b1; req_asid = asid[6:0]; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", {31'b0, busy}, 32'd1, "busy after accept");
    n = 0;
    while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
    if (!rsp_valid) chk("R9", 32'd0, 32'd1, "response timeout");
    else begin
      last_kind = rsp_kind;
      chk(rq, {30'b0, rsp_kind}, {30'b0, ek}, "fault kind");
      chk(rq, {31'b0, rsp_fault}, {31'b0, (ek != 2'd0)}, "fault flag");
      chk(ek == 2'd0 ? "R7" : "R10", {12'b0, rsp_pfn}, {12'b0, ep}, "frame");
      chk(ek == 2'd0 ? "R7" : "R10", {29'b0, rsp_perm}, {29'b0, eperm}, "perm");
      @(negedge clk);
      chk("R9", {31'b0, rsp_valid}, 32'd0, "pulse width");
      chk("R9", {31'b0, req_ready}, 32'd1, "idle after response");
    end
    chk(ek == 2'd2 ? "R4" : ek == 2'd1 ? "R5" : "R3", addr_log.size(), na, "read count");
    if (na >= 1 && addr_log.size() >= 1) chk("R3", addr_log[0], a0, "directory address");
    if (na >= 2 && addr_log.size() >= 2) chk("R3", addr_log[1], a1, "leaf address");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int asids [4];
    int dsel [4];
    int lsel [6];
    void'($urandom(32'd2024));
    rst = 1'b1; cfg_idx_we = 0; cfg_data_we = 0; cfg_wdata = '0;
    req_valid = 0; req_asid = '0; req_va = '0; req_write = 0; last_kind = '0;
    foreach (prog_tb[i]) begin prog_tb[i] = 1'b0; root_tb[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", {31'b0, busy}, 32'd0, "busy after reset");
    chk("R2", {31'b0, rsp_valid}, 32'd0, "rsp_valid after reset");
    chk("R2", {31'b0, mem_req_valid}, 32'd0, "mem_req_valid after reset");
    chk("R2", {31'b0, req_ready}, 32'd1, "req_ready after reset");

    // unprogrammed space: root reads as zero
    run(3, 32'h1234_5678, 1'b0);
    chk("R2", {30'b0, last_kind}, 32'd1, "unprogrammed ASID");

    // table set-up
    asids = '{2, 5, 9, 127};
    dsel  = '{0, 1, 'h2AA, 'h3FF};
    lsel  = '{0, 3, 'h155, 'h3FF, 'h0F0, 'h201};
    for (int k = 0; k < 4; k++) begin
      for (int d = 0; d < 4; d++) begin
        logic [19:0] lf;
        logic [31:0] dfr;
        int ty;
        lf  = 20'h40000 + 20'(k * 16 + d);
        dfr = {12'h0, 20'h01000 + 20'(k * 16)};
        ty  = $urandom % 5;
        case (ty)
          0: memw[{dfr[19:0], 10'(dsel[d]), 2'b00}] = 32'h0;
          1: memw[{dfr[19:0], 10'(dsel[d]), 2'b00}] = {12'hE00, lf};
          2: memw[{dfr[19:0], 10'(dsel[d]), 2'b00}] = {12'h100, lf};
          3: memw[{dfr[19:0], 10'(dsel[d]), 2'b00}] = {12'hF00, lf};
          default: memw[{dfr[19:0], 10'(dsel[d]), 2'b00}] = {12'h900, lf};
        endcase
        for (int l = 0; l < 6; l++)
          memw[{lf, 10'(lsel[l]), 2'b00}] = $urandom & 32'hE00F_FFFF;
      end
    end
    prog(32'd2,   {12'hE00, 20'h01000});
    prog(32'd5,   {12'h800, 20'h01010});
    prog(32'd9,   {12'hC00, 20'h01020});
    prog(32'd127, {12'h400, 20'h01030});

    // R1: selector takes only the low 7 bits; re-programming replaces the root
    prog(32'h0000_0F85, {12'hE00, 20'h01020});
    run(5, {10'h2AA, 10'h003, 12'h000}, 1'b0);
    if (addr_log.size() >= 1)
      chk("R1", addr_log[0], {20'h01020, 10'h2AA, 2'b00}, "root from reprogram");
    else
      chk("R1", 32'd0, 32'd1, "root from reprogram");
    prog(32'd5, {12'h800, 20'h01010});

    // directed corners: write to read-only space, read from write-only space
    run(5, {10'h001, 10'h003, 12'hABC}, 1'b1);
    chk("R5", {30'b0, last_kind}, 32'd1, "write to read-only root");
    run(127, {10'h001, 10'h003, 12'h000}, 1'b0);
    chk("R5", {30'b0, last_kind}, 32'd1, "read from write-only root");
    // directory index never populated
    run(2, {10'h155, 10'h003, 12'h000}, 1'b0);
    chk("R4", {30'b0, last_kind}, 32'd2, "absent directory entry");
    // leaf index never populated
    memw[{20'h01000, 10'h3FF, 2'b00}] = {12'hF00, 20'h40003};
    run(2, {10'h3FF, 10'h111, 12'h000}, 1'b0);
    chk("R6", {30'b0, last_kind}, 32'd3, "zero leaf");

    for (int t = 0; t < 500; t++) begin
      int a; logic [31:0] va; logic [9:0] di, li;
      a  = (($urandom % 10) == 0) ? 0 : asids[$urandom % 4];
      di = (($urandom % 8) != 0) ? 10'(dsel[$urandom % 4]) : 10'($urandom);
      li = (($urandom % 4) != 0) ? 10'(lsel[$urandom % 6]) : 10'($urandom);
      va = {di, li, 12'($urandom)};
      run(a, va, 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule